// File: doc/BRIEF.md
# Triggered trace capture buffer

This block records a parallel probe bus into an on-chip circular sample memory, the way an embedded logic analyzer does. After an arm command it writes one probe sample per clock, wrapping the write address around the memory depth. It keeps a chosen number of samples from before the trigger. When a trigger pulse is accepted it stores the rest of the memory from the trigger sample on, then freezes and raises a done flag. It also latches the address of the oldest stored sample, so a host-side reader can unload the memory in time order through a simple registered address/data port.

The trigger position is set per arm. It can be an explicit pre-trigger sample count anywhere in the depth, or one of three presets: a small pre-trigger share (about 5%), an even split, or a large pre-trigger share (about 95%). One-shot capture, with one buffer per arm, is always present. A build-time parameter can add a sample-after-trigger mode, in which nothing is recorded until the trigger and then the whole memory is filled from the trigger sample on. Event evaluation and the host transport lie outside this block.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, done_o is 0 and base_o is 0.
- R2: pos_sel_i selects the number of pre-trigger samples P: 0 = pos_custom_i, 1 = floor(DEPTH*5/100), 2 = DEPTH/2, 3 = floor(DEPTH*95/100). With DEPTH=64 the presets give 3, 32 and 60. The frozen buffer holds the P samples that precede the trigger sample, then DEPTH-P samples that start with the sample present in the trigger cycle.
- R3: Any custom P from 0 to DEPTH-1 is honoured, including both ends of that range.
- R4: After an arm, the P samples written in the P cycles that follow it form the pre-trigger fill. A trigger during the fill, including its last cycle, is ignored. The first cycle in which a trigger is accepted is the next one.
- R5: Sample k after the arm (k = 0, 1, ...) is written at address k mod DEPTH. On completion base_o holds the address of the oldest stored sample. Reading addresses base_o+i mod DEPTH, for i = 0..DEPTH-1, returns the buffer in time order. rd_data_o shows the word at rd_addr_i one clock after the address is presented.
- R6: done_o rises DEPTH-P-1 clock edges after the edge that accepts the trigger. It then stays 1 and the memory stays frozen until the next arm.
- R7: arm_i clears done_o and restarts capture from address 0 with newly sampled settings. This holds when the block is done and also while a capture is in progress.
- R8: A trigger while the block is not armed, or after capture is complete, has no effect: done_o, base_o and the memory contents are unchanged.
- R9: With SAT_EN=1 and mode_i=1 at arm, no sample is written before the trigger. DEPTH samples are stored starting with the trigger sample, base_o is 0, and done_o rises DEPTH-1 edges after the trigger edge.
- R10: With SAT_EN=0, mode_i is ignored and capture behaves as with mode_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| probe_i | input | DATA_W | Probe bus being recorded |
| arm_i | input | 1 | Arm pulse: samples settings and starts a capture |
| trig_i | input | 1 | Trigger pulse |
| pos_sel_i | input | 2 | Trigger position select (0 custom, 1 small, 2 half, 3 large pre-trigger share) |
| pos_custom_i | input | ADDR_W | Custom pre-trigger sample count |
| mode_i | input | 1 | 1 selects sample-after-trigger when built in |
| rd_addr_i | input | ADDR_W | Readout address |
| rd_data_o | output | DATA_W | Readout data, one clock after the address |
| done_o | output | 1 | Capture complete, held until the next arm |
| base_o | output | ADDR_W | Address of the oldest stored sample |

## Verification
The bench probes with a running stamp, so every stored word tells it when it was sampled. A trigger taken during the fill, or one cycle too late, shifts the whole buffer, and a wrong oldest-sample address rotates the readout. Both show up as stamp mismatches. It places triggers on the last fill cycle and on the first legal cycle, and uses custom positions 0 and DEPTH-1. It counts the edges to done, which catches an off-by-one post-trigger length. Re-arming mid-capture, late triggers after completion, and a build without the sample-after-trigger mode would expose, in turn, a block that keeps stale state, one that overwrites a frozen buffer, and one that honours a mode it was not built with.

// File: rtl/trace_pkg.sv
package trace_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FILL = 3'd1,
        ST_WAIT = 3'd2,
        ST_POST = 3'd3,
        ST_DONE = 3'd4
    } cap_state_e;

    typedef enum logic [1:0] {
        POS_CUSTOM = 2'd0,
        POS_EARLY  = 2'd1,
        POS_HALF   = 2'd2,
        POS_LATE   = 2'd3
    } pos_sel_e;
endpackage

// File: rtl/trace_pos.sv
module trace_pos #(
    parameter int AW     = 6,
    parameter bit SAT_EN = 1'b1
) (
    input  logic [1:0]  sel_i,
    input  logic [AW-1:0] custom_i,
    input  logic        mode_i,
    output logic [AW-1:0] pre_o,
    output logic [AW:0]   post_o,
    output logic        sat_o
);
    import trace_pkg::*;

    localparam int DEPTH   = 1 << AW;
    localparam int PRE_LO  = (DEPTH * 5) / 100;
    localparam int PRE_MID = DEPTH / 2;
    localparam int PRE_HI  = (DEPTH * 95) / 100;

    logic          sat;
    logic [AW-1:0] pre_sel;

    generate
        if (SAT_EN) begin : g_sat
            assign sat = mode_i;
        end else begin : g_nosat
            logic unused_mode;
            assign unused_mode = mode_i;
            assign sat = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (pos_sel_e'(sel_i))
            POS_EARLY: pre_sel = AW'(PRE_LO);
            POS_HALF:  pre_sel = AW'(PRE_MID);
            POS_LATE:  pre_sel = AW'(PRE_HI);
            default:   pre_sel = custom_i;
        endcase
    end

    assign pre_o  = sat ? '0 : pre_sel;
    assign post_o = (AW+1)'(DEPTH) - {1'b0, pre_o};
    assign sat_o  = sat;
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl #(
    parameter int AW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          arm_i,
    input  logic          trig_i,
    input  logic [AW-1:0] pre_i,
    input  logic [AW:0]   post_i,
    input  logic          sat_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          done_o,
    output logic [AW-1:0] base_o
);
    import trace_pkg::*;

    typedef struct packed {
        cap_state_e    st;
        logic [AW-1:0] ptr;
        logic [AW:0]   cnt;
        logic [AW-1:0] pre;
        logic [AW:0]   post;
        logic          sat;
        logic [AW-1:0] base;
        logic          done;
    } ctrl_t;

    ctrl_t q, d;
    logic  wr_en;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (arm_i) begin
            d.st   = (pre_i == '0) ? ST_WAIT : ST_FILL;
            d.ptr  = '0;
            d.cnt  = '0;
            d.pre  = pre_i;
            d.post = post_i;
            d.sat  = sat_i;
            d.base = '0;
            d.done = 1'b0;
        end else begin
            unique case (q.st)
                ST_FILL: begin
                    wr_en = 1'b1;
                    d.ptr = q.ptr + AW'(1);
                    d.cnt = q.cnt + (AW+1)'(1);
                    if (q.cnt + (AW+1)'(1) == {1'b0, q.pre}) begin
                        d.st = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (trig_i) begin
                        wr_en = 1'b1;
                        d.ptr = q.ptr + AW'(1);
                        if (q.post == (AW+1)'(1)) begin
                            d.st   = ST_DONE;
                            d.done = 1'b1;
                            d.base = q.ptr + AW'(1);
                        end else begin
                            d.st  = ST_POST;
                            d.cnt = (AW+1)'(1);
                        end
                    end else if (!q.sat) begin
                        wr_en = 1'b1;
                        d.ptr = q.ptr + AW'(1);
                    end
                end
                ST_POST: begin
                    wr_en = 1'b1;
                    d.ptr = q.ptr + AW'(1);
                    d.cnt = q.cnt + (AW+1)'(1);
                    if (q.cnt + (AW+1)'(1) == q.post) begin
                        d.st   = ST_DONE;
                        d.done = 1'b1;
                        d.base = q.ptr + AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign wr_en_o   = wr_en;
    assign wr_addr_o = q.ptr;
    assign done_o    = q.done;
    assign base_o    = q.base;

    // R4: no trigger accepted while the pre-trigger fill is running
    assert_fill_no_trig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_FILL) |=> (q.st != ST_POST) && (q.st != ST_DONE));

    // R5: every write moves the address by one, wrapping at the depth
    assert_ptr_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en |=> (q.ptr == $past(q.ptr) + AW'(1)));

    // R6: done holds until an arm
    assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.done && !arm_i) |=> q.done);

    // R6: memory frozen once done
    assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |-> !wr_en);

    // R6: completion only comes out of an active capture
    assert_done_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.done) |-> ($past(q.st) == ST_WAIT) || ($past(q.st) == ST_POST));

    // R7: arm clears done
    assert_arm_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> !q.done);

    // R8: trigger while idle does nothing
    assert_idle_trig_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IDLE && trig_i && !arm_i) |=> (q.st == ST_IDLE) && !q.done);

    // R9: sample-after-trigger writes nothing before the trigger
    assert_sat_no_pre_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.sat && q.st == ST_WAIT && !trig_i) |-> !wr_en);
endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    always_ff @(posedge clk_i) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    always_comb rd_d = mem[raddr_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rdata_o = rd_q;
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    parameter bit SAT_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] probe_i,
    input  logic              arm_i,
    input  logic              trig_i,
    input  logic [1:0]        pos_sel_i,
    input  logic [ADDR_W-1:0] pos_custom_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] base_o
);
    logic [ADDR_W-1:0] pre;
    logic [ADDR_W:0]   post;
    logic              sat;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;

    trace_pos #(.AW(ADDR_W), .SAT_EN(SAT_EN)) i_pos (
        .sel_i    (pos_sel_i),
        .custom_i (pos_custom_i),
        .mode_i   (mode_i),
        .pre_o    (pre),
        .post_o   (post),
        .sat_o    (sat)
    );

    trace_ctrl #(.AW(ADDR_W)) i_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .arm_i     (arm_i),
        .trig_i    (trig_i),
        .pre_i     (pre),
        .post_i    (post),
        .sat_i     (sat),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .done_o    (done_o),
        .base_o    (base_o)
    );

    trace_mem #(.DW(DATA_W), .AW(ADDR_W)) i_mem (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wdata_i (probe_i),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );
endmodule

// File: tb/test_trace_capture_buf.sv
`timescale 1ns/1ps
module test_trace_capture_buf;
    localparam int DW = 16;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] probe = '0;
    logic arm = 1'b0, trig = 1'b0, mode = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [AW-1:0] custom = '0;
    logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0;
    logic [DW-1:0] rd_a, rd_b;
    logic done_a, done_b;
    logic [AW-1:0] base_a, base_b;

    int total = 0, bad = 0;
    int stamp = 0;
    int a_st = 0, t_st = 0;
    logic [DW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    trace_capture_buf #(.DATA_W(DW), .ADDR_W(AW), .SAT_EN(1'b1)) i_trace_capture_buf (
        .clk_i(clk), .rst_ni(rst_n), .probe_i(probe), .arm_i(arm), .trig_i(trig),
        .pos_sel_i(sel), .pos_custom_i(custom), .mode_i(mode), .rd_addr_i(rd_addr_a),
        .rd_data_o(rd_a), .done_o(done_a), .base_o(base_a));

    trace_capture_buf #(.DATA_W(DW), .ADDR_W(AW), .SAT_EN(1'b0)) i_trace_capture_buf_nosat (
        .clk_i(clk), .rst_ni(rst_n), .probe_i(probe), .arm_i(arm), .trig_i(trig),
        .pos_sel_i(sel), .pos_custom_i(custom), .mode_i(mode), .rd_addr_i(rd_addr_b),
        .rd_data_o(rd_b), .done_o(done_b), .base_o(base_b));

    initial forever begin
        @(negedge clk);
        stamp = stamp + 1;
        probe = DW'(stamp);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_arm(input logic [1:0] s, input int c, input logic m);
        @(negedge clk);
        sel = s; custom = AW'(c); mode = m; arm = 1'b1;
        @(posedge clk); #1;
        a_st = stamp; arm = 1'b0;
    endtask

    task automatic do_trig(input int target);
        while (stamp + 1 < target) begin @(posedge clk); #1; end
        @(negedge clk);
        trig = 1'b1;
        @(posedge clk); #1;
        t_st = stamp; trig = 1'b0;
    endtask

    task automatic wait_done2(output int ka, output int kb);
        int k = 0;
        ka = -1; kb = -1;
        while (k < 300) begin
            if (done_a && ka < 0) ka = k;
            if (done_b && kb < 0) kb = k;
            if (ka >= 0 && kb >= 0) break;
            @(posedge clk); #1;
            k++;
        end
    endtask

    task automatic push_exp(input int t, input int pre);
        for (int i = 0; i < DEPTH; i++) exp_q.push_back(DW'(t - pre + i));
    endtask

    // monitor side of the scoreboard: reads and pops
    task automatic read_check(input bit which_b, input logic [AW-1:0] base, input string req);
        for (int i = 0; i < DEPTH; i++) begin
            logic [DW-1:0] got, e;
            @(negedge clk);
            if (which_b) rd_addr_b = base + AW'(i);
            else         rd_addr_a = base + AW'(i);
            @(posedge clk); #1;
            got = which_b ? rd_b : rd_a;
            e = exp_q.pop_front();
            chk(got == e, req, int'(got), int'(e));
        end
    endtask

    task automatic capture(input logic [1:0] s, input int c, input int pre, input int early, input int delay, input string req);
        int ka, kb;
        do_arm(s, c, 1'b0);
        if (early) begin
            do_trig(a_st + 1);
            do_trig(a_st + pre);
            chk(done_a == 1'b0, "R4 early trigger ignored", int'(done_a), 0);
        end
        do_trig(a_st + pre + 1 + delay);
        wait_done2(ka, kb);
        chk(ka == DEPTH - pre - 1, {req, " R6 done latency"}, ka, DEPTH - pre - 1);
        chk(int'(base_a) == ((t_st - pre - a_st - 1) & (DEPTH - 1)), {req, " R5 base"},
            int'(base_a), (t_st - pre - a_st - 1) & (DEPTH - 1));
        push_exp(t_st, pre);
        read_check(1'b0, base_a, {req, " R5 data"});
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ka, kb, last_t, last_pre;
        logic [AW-1:0] last_base;
        repeat (4) @(posedge clk);
        #1;
        chk(done_a == 1'b0, "R1 done after reset", int'(done_a), 0);
        chk(base_a == '0, "R1 base after reset", int'(base_a), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R8: trigger while idle
        do_trig(stamp + 2);
        repeat (3) @(posedge clk); #1;
        chk(done_a == 1'b0, "R8 idle trigger done", int'(done_a), 0);
        chk(base_a == '0, "R8 idle trigger base", int'(base_a), 0);

        // R3 / R4 custom position with ignored early triggers
        capture(2'd0, 10, 10, 1, 9, "R3 custom10");
        // R2 presets
        capture(2'd1, 0, (DEPTH * 5) / 100, 0, 5, "R2 early preset");
        capture(2'd2, 0, DEPTH / 2, 1, 0, "R2 half preset");
        capture(2'd3, 0, (DEPTH * 95) / 100, 0, 7, "R2 late preset");
        // R3 ends of range, R4 boundary
        capture(2'd0, 0, 0, 0, 3, "R3 custom0");
        capture(2'd0, DEPTH - 1, DEPTH - 1, 1, 0, "R3 custom max");
        last_t = t_st; last_pre = DEPTH - 1; last_base = base_a;

        // R8 / R6: late triggers after done, memory frozen
        do_trig(stamp + 2);
        do_trig(stamp + 5);
        repeat (80) @(posedge clk); #1;
        chk(done_a == 1'b1, "R6 done held", int'(done_a), 1);
        chk(base_a == last_base, "R8 base unchanged after done", int'(base_a), int'(last_base));
        push_exp(last_t, last_pre);
        read_check(1'b0, base_a, "R8 frozen data");

        // R7: arm clears done, then re-arm mid capture
        do_arm(2'd0, 10, 1'b0);
        chk(done_a == 1'b0, "R7 arm clears done", int'(done_a), 0);
        do_trig(a_st + 15);
        repeat (20) @(posedge clk);
        capture(2'd2, 0, DEPTH / 2, 0, 4, "R7 rearm mid capture");

        // R9 / R10: mode 1 on both builds
        do_arm(2'd0, 10, 1'b1);
        do_trig(a_st + 30);
        wait_done2(ka, kb);
        chk(ka == DEPTH - 1, "R9 done latency", ka, DEPTH - 1);
        chk(base_a == '0, "R9 base", int'(base_a), 0);
        chk(kb == DEPTH - 11, "R10 done latency", kb, DEPTH - 11);
        chk(int'(base_b) == ((t_st - 10 - a_st - 1) & (DEPTH - 1)), "R10 base",
            int'(base_b), (t_st - 10 - a_st - 1) & (DEPTH - 1));
        push_exp(t_st, 0);
        read_check(1'b0, base_a, "R9 data");
        push_exp(t_st, 10);
        read_check(1'b1, base_b, "R10 data");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule